// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Guard

This block sits on the controller side of a four-bank DDR SDRAM command bus. It watches every command the controller issues and keeps a record of which banks hold an open row. For each command it decides one of three outcomes:

- **Accepted:** the command is applied to the bank state.
- **Timing error:** the command arrived before one of the clock-cycle minimums had elapsed.
- **Protocol error:** the command targets a bank, or a set of banks, in the wrong open or closed state.

Commands that are rejected leave the state untouched.

Timing is kept by saturating down-counters that start at zero after reset. There is one set per bank: activate-to-activate, activate-to-column and activate-to-precharge. A second set is shared across banks: bank-to-bank activate spacing, write-to-read turnaround, refresh recovery, mode-register recovery and self-refresh exit. From these counters the block drives a ready vector for each command class. A scheduler can therefore pick a legal command before it issues it. The same decision logic grades the command actually issued.

Every minimum is a parameter, given in clock cycles. The defaults are the cycle counts of a 133 MHz part.

Top module: `ddr_bank_guard`

## Requirements
- R1: After reset all banks are closed. `rdy_act` is all ones, `rdy_ref` and `rdy_mrs` are high, `rdy_rd` and `rdy_wr` are zero, and no result pulse is raised.
- R2: Command code encoding is 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 MODE SET, and 7 NOP. Each non-NOP command with `cs_n` low yields exactly one of `cmd_accept`, `timing_err` or `proto_err`, pulsed in the cycle after the command is sampled. A NOP yields none.
- R3: A command sampled with `cs_n` high is ignored: no result pulse and no state change. Counters that are already running keep counting.
- R4: A READ or WRITE to a bank needs at least T_RCD (3) cycles after that bank's ACTIVATE.
- R5: On one bank, PRECHARGE needs T_RAS (6) cycles after ACTIVATE. ACTIVATE needs T_RP (3) cycles after PRECHARGE and T_RC (9) cycles after the previous ACTIVATE.
- R6: An ACTIVATE needs T_RRD (2) cycles after an ACTIVATE to any other bank.
- R7: PRECHARGE of a bank needs T_WR (2) cycles after a WRITE to it. A READ to any bank needs T_WTR+1 (2) cycles after any WRITE.
- R8: Address bit 10 high on READ or WRITE closes the bank with the command. After a WRITE of this kind the bank can be activated again after T_DAL (5) cycles. After a READ of this kind it can be activated again after T_RP (3) cycles.
- R9: On PRECHARGE, address bit 10 high closes every bank regardless of `ba`, and the timing check covers every open bank. Bit 10 low closes only bank `ba`. A PRECHARGE to a closed bank is accepted and has no effect.
- R10: REFRESH with any bank open is a protocol error. ACTIVATE or REFRESH needs T_RFC (10) cycles after a REFRESH.
- R11: Any command needs T_MRD (2) cycles after MODE SET. MODE SET with any bank open is a protocol error.
- R12: After a `sr_exit` pulse, non-read commands need T_XSNR (10) cycles and READ needs T_XSRD (200) cycles.
- R13: ACTIVATE to an open bank, or READ or WRITE to a closed bank, is a protocol error, and the bank state is left as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low to decode the command |
| cmd | input | 3 | Command code (see R2) |
| ba | input | BANK_BITS (2) | Bank address |
| addr | input | ADDR_W (12) | Address bus; bit AP_BIT (10) selects auto/all precharge |
| sr_exit | input | 1 | One-cycle pulse marking exit from self refresh |
| bank_open | output | NBANK (4) | Row-open flag per bank |
| rdy_act | output | NBANK (4) | ACTIVATE would be accepted, per bank |
| rdy_rd | output | NBANK (4) | READ would be accepted, per bank |
| rdy_wr | output | NBANK (4) | WRITE would be accepted, per bank |
| rdy_pre | output | NBANK (4) | Single-bank PRECHARGE would be accepted, per bank |
| rdy_pre_all | output | 1 | PRECHARGE with bit 10 high would be accepted |
| rdy_ref | output | 1 | REFRESH would be accepted |
| rdy_mrs | output | 1 | MODE SET would be accepted |
| cmd_accept | output | 1 | Previous command applied |
| timing_err | output | 1 | Previous command broke a cycle minimum |
| proto_err | output | 1 | Previous command hit a bank in the wrong state |

## Verification
For each minimum, the bench sweeps the gap from below to above the limit. A counter loaded one cycle short or one cycle long shows up as an accept or a timing error at the wrong gap.

Several limits can mask each other, so the bench stages commands so that only one limit is in play at a time:
- An auto-precharge write that reloads the wrong recovery shows up when the row cycle time is already satisfied.
- A precharge-all that checks only the addressed bank is caught by opening a second bank later than the addressed one.

Other cases target common slips:
- Chip-select-high cycles, to catch decoding while deselected or freezing the counters.
- The 200-cycle read window after self-refresh, to catch a read gated by the shorter non-read limit.
- Rejected commands, to catch state updated on a rejected command.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_REF  = 3'd5,
      CMD_MRS  = 3'd6,
      CMD_NOP2 = 3'd7
   } cmd_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dg_sat_timer.sv
module dg_sat_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          is_zero
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] dec_v;

   always_comb begin
      dec_v = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
   end

   // a load never shortens a window that is still running
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load && (load_val > dec_v))
         cnt_q <= load_val;
      else
         cnt_q <= dec_v;
   end

   assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
   parameter int CW    = 8,
   parameter int T_RC  = 9,
   parameter int T_RCD = 3,
   parameter int T_RAS = 6,
   parameter int T_RP  = 3,
   parameter int T_WR  = 2,
   parameter int T_DAL = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic do_act,
   input  logic do_wr,
   input  logic do_rd_ap,
   input  logic do_wr_ap,
   input  logic do_pre,
   output logic is_open,
   output logic act_ok,
   output logic rw_ok,
   output logic pre_ok
);

   localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
   localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
   localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
   localparam logic [CW-1:0] LD_WR  = CW'(T_WR - 1);
   localparam logic [CW-1:0] LD_DAL = CW'(T_DAL - 1);

   logic          act_ld, pre_ld;
   logic [CW-1:0] act_val, pre_val;
   logic          open_q;

   always_comb begin
      act_ld  = do_act | do_pre | do_rd_ap | do_wr_ap;
      act_val = do_act   ? LD_RC  :
                do_wr_ap ? LD_DAL : LD_RP;
      pre_ld  = do_act | do_wr;
      pre_val = do_act ? LD_RAS : LD_WR;
   end

   dg_sat_timer #(.CW(CW)) u_act (
      .clk(clk), .rst_n(rst_n), .load(act_ld), .load_val(act_val), .is_zero(act_ok));
   dg_sat_timer #(.CW(CW)) u_rw (
      .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(LD_RCD), .is_zero(rw_ok));
   dg_sat_timer #(.CW(CW)) u_pre (
      .clk(clk), .rst_n(rst_n), .load(pre_ld), .load_val(pre_val), .is_zero(pre_ok));

   always_ff @(posedge clk) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (do_act)
         open_q <= 1'b1;
      else if (do_pre || do_rd_ap || do_wr_ap)
         open_q <= 1'b0;
   end

   assign is_open = open_q;

endmodule

// File: rtl/ddr_global_track.sv
module ddr_global_track #(
   parameter int CW     = 8,
   parameter int T_RRD  = 2,
   parameter int T_WTR  = 1,
   parameter int T_RFC  = 10,
   parameter int T_MRD  = 2,
   parameter int T_XSNR = 10,
   parameter int T_XSRD = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_any,
   input  logic wr_any,
   input  logic ref_go,
   input  logic mrs_go,
   input  logic sr_exit,
   output logic rrd_ok,
   output logic wtr_ok,
   output logic rfc_ok,
   output logic mrd_ok,
   output logic xs_ok,
   output logic xsrd_ok
);

   localparam int NT = 6;
   // turnaround loads T_WTR so a read waits T_WTR idle cycles
   localparam int LV [NT] = '{T_RRD - 1, T_WTR, T_RFC - 1, T_MRD - 1,
                              T_XSNR - 1, T_XSRD - 1};

   logic [NT-1:0] ld_v;
   logic [NT-1:0] ok_v;

   assign ld_v = {sr_exit, sr_exit, mrs_go, ref_go, wr_any, act_any};

   for (genvar i = 0; i < NT; i++) begin : g_tmr
      dg_sat_timer #(.CW(CW)) u_tmr (
         .clk(clk), .rst_n(rst_n), .load(ld_v[i]),
         .load_val(CW'(LV[i])), .is_zero(ok_v[i]));
   end

   assign {xsrd_ok, xs_ok, mrd_ok, rfc_ok, wtr_ok, rrd_ok} = ok_v;

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
   import ddr_guard_pkg::*;
#(
   parameter int BANK_BITS = 2,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 6,
   parameter int T_RC      = 9,
   parameter int T_RFC     = 10,
   parameter int T_RRD     = 2,
   parameter int T_WR      = 2,
   parameter int T_WTR     = 1,
   parameter int T_DAL     = 5,
   parameter int T_MRD     = 2,
   parameter int T_XSNR    = 10,
   parameter int T_XSRD    = 200,
   localparam int NBANK    = 1 << BANK_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic [2:0]           cmd,
   input  logic [BANK_BITS-1:0] ba,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 sr_exit,
   output logic [NBANK-1:0]     bank_open,
   output logic [NBANK-1:0]     rdy_act,
   output logic [NBANK-1:0]     rdy_rd,
   output logic [NBANK-1:0]     rdy_wr,
   output logic [NBANK-1:0]     rdy_pre,
   output logic                 rdy_pre_all,
   output logic                 rdy_ref,
   output logic                 rdy_mrs,
   output logic                 cmd_accept,
   output logic                 timing_err,
   output logic                 proto_err
);

   localparam int TMAX = umax(umax(umax(T_RC, T_RFC), umax(T_XSNR, T_XSRD)),
                              umax(umax(T_RAS, T_DAL), umax(T_WTR + 1, T_MRD)));
   localparam int CW   = $clog2(TMAX + 1);

   // elaboration-time parameter checks
   if (BANK_BITS < 1)       begin : g_bad_bb  $error("BANK_BITS must be at least 1"); end
   if (AP_BIT >= ADDR_W)    begin : g_bad_ap  $error("AP_BIT must lie inside the address bus"); end
   if (T_RCD < 1 || T_RP < 1 || T_RAS < 1 || T_RC < 1 || T_RFC < 1 ||
       T_RRD < 1 || T_WR < 1 || T_DAL < 1 || T_MRD < 1 || T_XSNR < 1)
                            begin : g_bad_min $error("cycle minimums must be at least 1"); end
   if (T_WTR < 0)           begin : g_bad_wtr $error("T_WTR must not be negative"); end
   if (T_XSRD < T_XSNR)     begin : g_bad_xs  $error("read exit window shorter than non-read"); end

   cmd_e             cmd_c;
   logic             is_act, is_rd, is_wr, is_pre, is_ref, is_mrs, has_cmd;
   logic             ap_bit, any_open, idle_ok, proto_v, time_ok, go;
   logic [NBANK-1:0] sel, act_ok, rw_ok, pre_ok;
   logic [NBANK-1:0] s_act, s_wr, s_rd_ap, s_wr_ap, s_pre;
   logic             rrd_ok, wtr_ok, rfc_ok, mrd_ok, xs_ok, xsrd_ok;

   // ---------------- command decode ----------------
   always_comb begin
      cmd_c  = cmd_e'(cmd);
      is_act = !cs_n && (cmd_c == CMD_ACT);
      is_rd  = !cs_n && (cmd_c == CMD_RD);
      is_wr  = !cs_n && (cmd_c == CMD_WR);
      is_pre = !cs_n && (cmd_c == CMD_PRE);
      is_ref = !cs_n && (cmd_c == CMD_REF);
      is_mrs = !cs_n && (cmd_c == CMD_MRS);
      has_cmd = is_act | is_rd | is_wr | is_pre | is_ref | is_mrs;
      ap_bit = addr[AP_BIT];
      sel    = NBANK'(1) << ba;
   end

   // ---------------- ready vectors ----------------
   always_comb begin
      any_open = |bank_open;
      idle_ok  = !any_open && (&act_ok) && rfc_ok && mrd_ok && xs_ok;
      for (int b = 0; b < NBANK; b++) begin
         rdy_act[b] = !bank_open[b] && act_ok[b] && rrd_ok && rfc_ok && mrd_ok && xs_ok;
         rdy_rd[b]  = bank_open[b] && rw_ok[b] && wtr_ok && mrd_ok && xsrd_ok;
         rdy_wr[b]  = bank_open[b] && rw_ok[b] && mrd_ok && xs_ok;
         rdy_pre[b] = (!bank_open[b] || pre_ok[b]) && mrd_ok && xs_ok;
      end
      rdy_pre_all = &rdy_pre;
      rdy_ref     = idle_ok;
      rdy_mrs     = idle_ok;
   end

   // ---------------- grading ----------------
   always_comb begin
      proto_v = (is_act && bank_open[ba]) ||
                ((is_rd || is_wr) && !bank_open[ba]) ||
                ((is_ref || is_mrs) && any_open);
      unique case (1'b1)
         is_act:  time_ok = rdy_act[ba];
         is_rd:   time_ok = rdy_rd[ba];
         is_wr:   time_ok = rdy_wr[ba];
         is_pre:  time_ok = ap_bit ? rdy_pre_all : rdy_pre[ba];
         is_ref:  time_ok = rdy_ref;
         is_mrs:  time_ok = rdy_mrs;
         default: time_ok = 1'b1;
      endcase
      go = has_cmd && !proto_v && time_ok;
   end

   // ---------------- per-bank strobes ----------------
   always_comb begin
      for (int b = 0; b < NBANK; b++) begin
         s_act[b]   = go && is_act && sel[b];
         s_wr[b]    = go && is_wr && sel[b];
         s_rd_ap[b] = go && is_rd && ap_bit && sel[b];
         s_wr_ap[b] = go && is_wr && ap_bit && sel[b];
         s_pre[b]   = go && is_pre && (ap_bit || sel[b]) && bank_open[b];
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      ddr_bank_track #(
         .CW(CW), .T_RC(T_RC), .T_RCD(T_RCD), .T_RAS(T_RAS),
         .T_RP(T_RP), .T_WR(T_WR), .T_DAL(T_DAL)
      ) u_trk (
         .clk(clk), .rst_n(rst_n),
         .do_act(s_act[b]), .do_wr(s_wr[b]),
         .do_rd_ap(s_rd_ap[b]), .do_wr_ap(s_wr_ap[b]), .do_pre(s_pre[b]),
         .is_open(bank_open[b]), .act_ok(act_ok[b]),
         .rw_ok(rw_ok[b]), .pre_ok(pre_ok[b])
      );
   end

   ddr_global_track #(
      .CW(CW), .T_RRD(T_RRD), .T_WTR(T_WTR), .T_RFC(T_RFC),
      .T_MRD(T_MRD), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)
   ) u_glb (
      .clk(clk), .rst_n(rst_n),
      .act_any(go && is_act), .wr_any(go && is_wr),
      .ref_go(go && is_ref), .mrs_go(go && is_mrs), .sr_exit(sr_exit),
      .rrd_ok(rrd_ok), .wtr_ok(wtr_ok), .rfc_ok(rfc_ok),
      .mrd_ok(mrd_ok), .xs_ok(xs_ok), .xsrd_ok(xsrd_ok)
   );

   // ---------------- result pulses ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_accept <= 1'b0;
         timing_err <= 1'b0;
         proto_err  <= 1'b0;
      end else begin
         cmd_accept <= go;
         timing_err <= has_cmd && !proto_v && !time_ok;
         proto_err  <= has_cmd && proto_v;
      end
   end

endmodule

// File: rtl/ddr_bank_guard_chk.sv
module ddr_bank_guard_chk #(
   parameter int BANK_BITS = 2,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10,
   localparam int NBANK    = 1 << BANK_BITS
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic [2:0]           cmd,
   input logic [BANK_BITS-1:0] ba,
   input logic [ADDR_W-1:0]    addr,
   input logic [NBANK-1:0]     bank_open,
   input logic [NBANK-1:0]     rdy_act,
   input logic                 rdy_pre_all,
   input logic                 cmd_accept,
   input logic                 timing_err,
   input logic                 proto_err
);

   assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_accept, timing_err, proto_err}));

   assert_deselect_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !(cmd_accept || timing_err || proto_err) && $stable(bank_open));

   assert_ready_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && cmd == 3'd1 && rdy_act[ba]) |=> cmd_accept && bank_open[$past(ba)]);

   assert_pre_all_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && cmd == 3'd4 && addr[AP_BIT] && rdy_pre_all) |=> (bank_open == '0));

   assert_ref_open_rejected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && cmd == 3'd5 && (|bank_open)) |=> proto_err && $stable(bank_open));

   assert_rw_closed_rejected_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && (cmd == 3'd2 || cmd == 3'd3) && !bank_open[ba]) |=> proto_err && $stable(bank_open));

endmodule

bind ddr_bank_guard ddr_bank_guard_chk #(
   .BANK_BITS(BANK_BITS), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .ba(ba), .addr(addr),
   .bank_open(bank_open), .rdy_act(rdy_act), .rdy_pre_all(rdy_pre_all),
   .cmd_accept(cmd_accept), .timing_err(timing_err), .proto_err(proto_err)
);

// File: tb/ddr_bank_guard_tb.sv
module ddr_bank_guard_tb;

   // minimums from the requirements, in cycles
   localparam int RCD = 3, RP = 3, RAS = 6, RC = 9, RFC = 10, RRD = 2;
   localparam int WR = 2, WTR = 1, DAL = 5, MRD = 2, XSNR = 10, XSRD = 200;
   localparam int NOP = 0, ACT = 1, RD = 2, WRC = 3, PRE = 4, REF = 5, MRS = 6;
   localparam int A10 = 1 << 10;
   localparam logic [2:0] ACC = 3'b100, TER = 3'b010, PER = 3'b001, NONE = 3'b000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b0;
   logic [2:0]  cmd = '0;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic        sr_exit = 1'b0;
   logic [3:0]  bank_open, rdy_act, rdy_rd, rdy_wr, rdy_pre;
   logic        rdy_pre_all, rdy_ref, rdy_mrs, cmd_accept, timing_err, proto_err;

   int n_vec = 0;
   int n_bad = 0;
   logic [2:0] res;

   always #10 clk = ~clk;

   ddr_bank_guard u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .ba(ba), .addr(addr),
      .sr_exit(sr_exit), .bank_open(bank_open), .rdy_act(rdy_act), .rdy_rd(rdy_rd),
      .rdy_wr(rdy_wr), .rdy_pre(rdy_pre), .rdy_pre_all(rdy_pre_all),
      .rdy_ref(rdy_ref), .rdy_mrs(rdy_mrs), .cmd_accept(cmd_accept),
      .timing_err(timing_err), .proto_err(proto_err));

   // drive at a falling edge, let one rising edge sample it, read the result
   task automatic issue(input int c, input int b, input int a, input bit desel = 1'b0);
      cs_n = desel; cmd = 3'(c); ba = 2'(b); addr = 12'(a);
      @(negedge clk);
      res = {cmd_accept, timing_err, proto_err};
      cs_n = 1'b0; cmd = '0; ba = '0; addr = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) issue(NOP, 0, 0);
   endtask

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cs_n = 1'b0; cmd = '0; sr_exit = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // first command, gap cycles later the second; grade against the minimum
   task automatic gap_pair(input int ca, input int bA, input int aA,
                           input int cb, input int bB, input int aB,
                           input int gap, input int mn, input string tag);
      issue(ca, bA, aA);
      idle(gap - 1);
      issue(cb, bB, aB);
      check(res, (gap >= mn) ? ACC : TER, $sformatf("%s gap=%0d", tag, gap));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      // R1 reset state
      do_reset();
      check({bank_open, rdy_act, rdy_rd, rdy_wr}, {4'h0, 4'hF, 4'h0, 4'h0}, "R1 vectors");
      check({rdy_ref, rdy_mrs, cmd_accept, timing_err, proto_err}, 5'b11000, "R1 flags");

      // R2 NOP codes produce nothing
      issue(NOP, 0, 0); check(res, NONE, "R2 nop0");
      issue(7, 1, 0);   check(res, NONE, "R2 nop7");

      // R4 activate to column
      for (int g = 1; g <= 5; g++) begin
         do_reset(); gap_pair(ACT, 0, 0, RD, 0, 0, g, RCD, "R4 rd");
         do_reset(); gap_pair(ACT, 1, 0, WRC, 1, 0, g, RCD, "R4 wr");
      end

      // R5 activate to precharge
      for (int g = 4; g <= 8; g++) begin
         do_reset(); gap_pair(ACT, 2, 0, PRE, 2, 0, g, RAS, "R5 ras");
      end
      // R5 precharge to activate
      for (int g = 1; g <= 5; g++) begin
         do_reset(); issue(ACT, 0, 0); idle(9);
         gap_pair(PRE, 0, 0, ACT, 0, 0, g, RP, "R5 rp");
      end
      // R5 activate to activate, same bank
      for (int g = 7; g <= 11; g++) begin
         do_reset(); issue(ACT, 3, 0); idle(RAS - 1); issue(PRE, 3, 0);
         idle(g - RAS - 1); issue(ACT, 3, 0);
         check(res, (g >= RC) ? ACC : TER, $sformatf("R5 rc gap=%0d", g));
      end

      // R6 bank to bank activate
      for (int g = 1; g <= 4; g++) begin
         do_reset(); gap_pair(ACT, 0, 0, ACT, 1, 0, g, RRD, "R6 rrd");
      end

      // R7 write recovery and write-to-read
      for (int g = 1; g <= 4; g++) begin
         do_reset(); issue(ACT, 0, 0); idle(RAS - 1);
         gap_pair(WRC, 0, 0, PRE, 0, 0, g, WR, "R7 wr");
         do_reset(); issue(ACT, 0, 0); idle(1); issue(ACT, 1, 0); idle(9);
         gap_pair(WRC, 0, 0, RD, 1, 0, g, WTR + 1, "R7 wtr");
      end

      // R8 auto-precharge
      for (int g = 3; g <= 7; g++) begin
         do_reset(); issue(ACT, 0, 0); idle(RAS - 1);
         gap_pair(WRC, 0, A10, ACT, 0, 0, g, DAL, "R8 wr-ap");
      end
      for (int g = 1; g <= 5; g++) begin
         do_reset(); issue(ACT, 1, 0); idle(RAS - 1);
         gap_pair(RD, 1, A10, ACT, 1, 0, g, RP, "R8 rd-ap");
      end
      do_reset(); issue(ACT, 2, 0); idle(RAS - 1); issue(WRC, 2, A10);
      check(res, ACC, "R8 wr-ap accepted");
      check(bank_open, 4'h0, "R8 bank closed");
      issue(RD, 2, 0); check(res, PER, "R8 read after close");

      // R9 precharge all, timing across every open bank
      for (int g = 6; g <= 10; g++) begin
         do_reset(); issue(ACT, 0, 0); idle(1); issue(ACT, 2, 0);
         idle(g - 3); issue(PRE, 1, A10);
         check(res, (g >= 2 + RAS) ? ACC : TER, $sformatf("R9 pre-all gap=%0d", g));
         check(bank_open, (g >= 2 + RAS) ? 4'h0 : 4'h5, $sformatf("R9 state gap=%0d", g));
      end
      do_reset(); issue(ACT, 0, 0); idle(1); issue(ACT, 2, 0); idle(9);
      issue(PRE, 0, 0); check(res, ACC, "R9 single pre");
      check(bank_open, 4'h4, "R9 other bank stays open");
      issue(RD, 2, 0); check(res, ACC, "R9 read open bank");
      do_reset(); issue(PRE, 3, 0); check(res, ACC, "R9 pre closed bank");

      // R10 refresh
      do_reset(); issue(ACT, 1, 0); idle(9); issue(REF, 0, 0);
      check(res, PER, "R10 ref with open bank");
      check(bank_open, 4'h2, "R10 state kept");
      for (int g = 8; g <= 12; g++) begin
         do_reset(); gap_pair(REF, 0, 0, ACT, 2, 0, g, RFC, "R10 rfc act");
         do_reset(); gap_pair(REF, 0, 0, REF, 0, 0, g, RFC, "R10 rfc ref");
      end

      // R11 mode set
      for (int g = 1; g <= 3; g++) begin
         do_reset(); gap_pair(MRS, 0, 0, ACT, 1, 0, g, MRD, "R11 mrd");
         do_reset(); gap_pair(MRS, 0, 0, PRE, 0, 0, g, MRD, "R11 mrd pre");
      end
      do_reset(); issue(ACT, 3, 0); idle(9); issue(MRS, 0, 0);
      check(res, PER, "R11 mrs with open bank");

      // R12 self refresh exit
      for (int g = 8; g <= 11; g++) begin
         do_reset(); sr_exit = 1'b1; issue(NOP, 0, 0); sr_exit = 1'b0;
         idle(g - 1); issue(ACT, 0, 0);
         check(res, (g >= XSNR) ? ACC : TER, $sformatf("R12 xsnr gap=%0d", g));
      end
      for (int g = 198; g <= 201; g++) begin
         do_reset(); sr_exit = 1'b1; issue(NOP, 0, 0); sr_exit = 1'b0;
         idle(XSNR - 1); issue(ACT, 0, 0);
         idle(g - XSNR - 1); issue(RD, 0, 0);
         check(res, (g >= XSRD) ? ACC : TER, $sformatf("R12 xsrd gap=%0d", g));
      end

      // R3 deselected commands
      do_reset(); issue(ACT, 0, 0, 1'b1);
      check(res, NONE, "R3 no pulse");
      check(bank_open, 4'h0, "R3 no state change");
      issue(RD, 0, 0); check(res, PER, "R3 bank still closed");
      do_reset(); issue(ACT, 0, 0); issue(RD, 0, 0, 1'b1); issue(WRC, 0, 0, 1'b1);
      issue(RD, 0, 0); check(res, ACC, "R3 counters keep running");

      // R13 wrong-state commands
      do_reset(); issue(ACT, 0, 0); idle(9); issue(ACT, 0, 0);
      check(res, PER, "R13 act open bank");
      check(bank_open, 4'h1, "R13 state kept");
      issue(RD, 0, 0); check(res, ACC, "R13 bank still usable");
      issue(WRC, 3, 0); check(res, PER, "R13 write closed bank");

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule